// File: doc/BRIEF.md
# Scaled Displacement Address Generator

This block forms effective addresses for load and store operations from fields that are already decoded. Its inputs are a base value, an optional index value with a scale code, and a displacement with a width class. It also takes the element size of the access and a per-operation flag that selects whether a medium displacement is taken as a byte offset. How the displacement is scaled depends on its width class. Short displacements always count in elements. Medium displacements count in elements or in bytes, as the flag selects. Full-width displacements are always byte values, so the base acts as an offset added to an absolute address.

The index can be multiplied by the powers of two 1, 2, 4 and 8, and also by 5 or 10. Both of these are built from shifts and one add. Every term is sign-extended to 64 bits, and the sum wraps modulo 2^64. A request is accepted on a valid strobe. The address and its valid flag are registered and appear one cycle later. Between requests the registered address holds its value.

Top module: `agu_addr_gen`

## Requirements
- R1: When in_valid is high at a rising edge, out_valid_o is high after that edge and addr_o holds base + index term + displacement term; when in_valid is low at an edge, out_valid_o is low after it.
- R2: While in_valid is low, addr_o keeps its last value whatever the other inputs do.
- R3: disp_cls_i = 0 (short) uses disp_i[9:0] sign-extended, shifted left by elem_sz_i (0 byte, 1 half, 2 word, 3 double); bits above 9 and disp_bytes_i are ignored.
- R4: disp_cls_i = 1 (medium) uses disp_i[32:0] sign-extended; with disp_bytes_i = 0 it is shifted left by elem_sz_i, with disp_bytes_i = 1 it is used unshifted; bits above 32 are ignored.
- R5: disp_cls_i = 2 or 3 (full) uses all 64 bits of disp_i unshifted, regardless of disp_bytes_i and elem_sz_i.
- R6: idx_scale_i codes 0, 1, 2, 3 multiply the index by 1, 2, 4, 8.
- R7: idx_scale_i code 4 multiplies the index by 5, code 5 by 10, and codes 6 and 7 by 1.
- R8: With idx_en_i low the index term is zero whatever idx_i and idx_scale_i hold.
- R9: The sum wraps modulo 2^64.
- R10: During and directly after reset, out_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| base_i | input | 64 | Base value |
| idx_en_i | input | 1 | Index term enable |
| idx_i | input | 64 | Index value |
| idx_scale_i | input | 3 | Index scale code |
| disp_i | input | 64 | Displacement, low bits used per class |
| disp_cls_i | input | 2 | Displacement width class |
| disp_bytes_i | input | 1 | Medium displacement taken as bytes |
| elem_sz_i | input | 2 | Access element size code |
| out_valid_o | output | 1 | Address valid |
| addr_o | output | 64 | Effective address |

## Verification
Every address result and its valid flag are due at the first rising edge after the edge that captured in_valid. The bench drives each request on a falling edge, waits for the next rising edge, and samples one time unit later. Hold behaviour and the drop of the valid flag are checked after one and two further edges with in_valid low, while the other inputs are changed. Expected addresses come from a hand-computed table of small and boundary values.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned SHORT_W = 10;
  localparam int unsigned MED_W   = 33;

  typedef enum logic [1:0] {
    DCLS_SHORT = 2'd0,
    DCLS_MED   = 2'd1,
    DCLS_FULL  = 2'd2,
    DCLS_FULL2 = 2'd3
  } disp_cls_e;

  typedef enum logic [2:0] {
    XS_1   = 3'd0,
    XS_2   = 3'd1,
    XS_4   = 3'd2,
    XS_8   = 3'd3,
    XS_5   = 3'd4,
    XS_10  = 3'd5,
    XS_R6  = 3'd6,
    XS_R7  = 3'd7
  } idx_scale_e;
endpackage

// File: rtl/agu_disp_term.sv
module agu_disp_term
  import agu_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned SW  = SHORT_W,
  parameter int unsigned MW  = MED_W
) (
  input  logic [AW-1:0] disp_i,
  input  logic [1:0]    cls_i,
  input  logic          bytes_i,
  input  logic [1:0]    esz_i,
  output logic [AW-1:0] term_o
);
  localparam int unsigned SPAD = AW - SW;
  localparam int unsigned MPAD = AW - MW;

  logic [AW-1:0] short_ext;
  logic [AW-1:0] med_ext;

  always_comb begin
    short_ext = {{SPAD{disp_i[SW-1]}}, disp_i[SW-1:0]};
    med_ext   = {{MPAD{disp_i[MW-1]}}, disp_i[MW-1:0]};
    unique case (disp_cls_e'(cls_i))
      DCLS_SHORT: term_o = short_ext << esz_i;
      DCLS_MED:   term_o = bytes_i ? med_ext : (med_ext << esz_i);
      default:    term_o = disp_i;
    endcase
  end

  // R5: full class passes the displacement through untouched
  always_comb begin
    if (!$isunknown({cls_i, disp_i}) && cls_i[1])
      a_r5_full_unscaled: assert (term_o == disp_i);
  end

  // R3: a scaled short term has elem_sz low bits clear
  always_comb begin
    if (!$isunknown({cls_i, esz_i, term_o}) && cls_i == 2'd0)
      a_r3_short_aligned: assert ((term_o & ((64'd1 << esz_i) - 64'd1)) == '0);
  end
endmodule

// File: rtl/agu_index_term.sv
module agu_index_term
  import agu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] idx_i,
  input  logic          en_i,
  input  logic [2:0]    scale_i,
  output logic [AW-1:0] term_o
);
  logic [AW-1:0] times5;
  logic [AW-1:0] scaled;

  always_comb begin
    times5 = (idx_i << 2) + idx_i;
    unique case (idx_scale_e'(scale_i))
      XS_1:    scaled = idx_i;
      XS_2:    scaled = idx_i << 1;
      XS_4:    scaled = idx_i << 2;
      XS_8:    scaled = idx_i << 3;
      XS_5:    scaled = times5;
      XS_10:   scaled = times5 << 1;
      default: scaled = idx_i;
    endcase
    term_o = en_i ? scaled : '0;
  end

  // R8: disabled index contributes nothing
  always_comb begin
    if (!$isunknown({en_i, term_o}) && !en_i)
      a_r8_index_off: assert (term_o == '0);
  end

  // R7: code 4 equals a true multiply by five
  always_comb begin
    if (!$isunknown({en_i, scale_i, idx_i}) && en_i && scale_i == 3'd4)
      a_r7_times5: assert (term_o == idx_i * 64'd5);
  end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
  import agu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] base_i,
  input  logic          idx_en_i,
  input  logic [AW-1:0] idx_i,
  input  logic [2:0]    idx_scale_i,
  input  logic [AW-1:0] disp_i,
  input  logic [1:0]    disp_cls_i,
  input  logic          disp_bytes_i,
  input  logic [1:0]    elem_sz_i,
  output logic          out_valid_o,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] disp_term;
  logic [AW-1:0] idx_term;
  logic [AW-1:0] sum;
  logic [AW-1:0] addr_d, addr_q;
  logic          vld_d, vld_q;

  agu_disp_term #(.AW(AW)) u_disp (
    .disp_i  (disp_i),
    .cls_i   (disp_cls_i),
    .bytes_i (disp_bytes_i),
    .esz_i   (elem_sz_i),
    .term_o  (disp_term)
  );

  agu_index_term #(.AW(AW)) u_idx (
    .idx_i   (idx_i),
    .en_i    (idx_en_i),
    .scale_i (idx_scale_i),
    .term_o  (idx_term)
  );

  // next state
  always_comb begin
    sum    = base_i + idx_term + disp_term;
    vld_d  = in_valid;
    addr_d = in_valid ? sum : addr_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (in_valid) addr_q <= addr_d;
    end
  end

  assign out_valid_o = vld_q;
  assign addr_o      = addr_q;

  // R1: valid follows the strobe by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid_o);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid_o);
  // R2: address holds while idle
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(addr_o));
endmodule

// File: tb/agu_addr_gen_tb.sv
module agu_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] base_i, idx_i, disp_i;
  logic        idx_en_i, disp_bytes_i;
  logic [2:0]  idx_scale_i;
  logic [1:0]  disp_cls_i, elem_sz_i;
  logic        out_valid_o;
  logic [63:0] addr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  agu_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_i(base_i),
    .idx_en_i(idx_en_i), .idx_i(idx_i), .idx_scale_i(idx_scale_i),
    .disp_i(disp_i), .disp_cls_i(disp_cls_i), .disp_bytes_i(disp_bytes_i),
    .elem_sz_i(elem_sz_i), .out_valid_o(out_valid_o), .addr_o(addr_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [63:0] base;
    logic        en;
    logic [63:0] idx;
    logic [2:0]  sc;
    logic [63:0] disp;
    logic [1:0]  cls;
    logic        byt;
    logic [1:0]  esz;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R8 index disabled, R3 short scaled by 8
    '{8'd8, 64'h1000, 1'b0, 64'd7, 3'd3, 64'h4, 2'd0, 1'b0, 2'd3, 64'h1020},
    // R3 short negative scaled by 4
    '{8'd3, 64'h1000, 1'b0, 64'd0, 3'd0, 64'h3FF, 2'd0, 1'b0, 2'd2, 64'hFFC},
    // R4 medium most negative scaled by 8 (-32 GB)
    '{8'd4, 64'h0, 1'b0, 64'd0, 3'd0, 64'h1_0000_0000, 2'd1, 1'b0, 2'd3, 64'hFFFF_FFF8_0000_0000},
    // R4 medium max positive unscaled
    '{8'd4, 64'h10, 1'b0, 64'd0, 3'd0, 64'h0_FFFF_FFFF, 2'd1, 1'b1, 2'd3, 64'h1_0000_000F},
    // R5 full class never scaled
    '{8'd5, 64'h5, 1'b0, 64'd0, 3'd0, 64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd3, 64'h8000_0000_0000_0005},
    // R5 class 3 also full
    '{8'd5, 64'h1, 1'b0, 64'd0, 3'd0, 64'h100, 2'd3, 1'b0, 2'd2, 64'h101},
    // R7 times 5
    '{8'd7, 64'h100, 1'b1, 64'd3, 3'd4, 64'h0, 2'd0, 1'b0, 2'd0, 64'h10F},
    // R7 times 10
    '{8'd7, 64'h100, 1'b1, 64'd3, 3'd5, 64'h0, 2'd0, 1'b0, 2'd0, 64'h11E},
    // R7 reserved code 6 acts as 1
    '{8'd7, 64'h0, 1'b1, 64'd9, 3'd6, 64'h0, 2'd0, 1'b0, 2'd0, 64'h9},
    // R6 times 8 with R4 scaled medium by 2
    '{8'd6, 64'h0, 1'b1, 64'h10, 3'd3, 64'h2, 2'd1, 1'b0, 2'd1, 64'h84},
    // R6 times 2
    '{8'd6, 64'h0, 1'b1, 64'd7, 3'd1, 64'h0, 2'd0, 1'b0, 2'd0, 64'hE},
    // R6 times 4
    '{8'd6, 64'h0, 1'b1, 64'd7, 3'd2, 64'h0, 2'd0, 1'b0, 2'd0, 64'h1C},
    // R9 wrap to zero
    '{8'd9, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'd1, 3'd0, 64'h0, 2'd0, 1'b0, 2'd0, 64'h0},
    // R3 upper displacement bits ignored
    '{8'd3, 64'h10, 1'b0, 64'd0, 3'd0, 64'hFFFF_F001, 2'd0, 1'b0, 2'd0, 64'h11},
    // R4 bits above 32 ignored
    '{8'd4, 64'h0, 1'b0, 64'd0, 3'd0, 64'hABCD_0000_0000_0010, 2'd1, 1'b1, 2'd3, 64'h10},
    // R3 byte flag ignored for short
    '{8'd3, 64'h0, 1'b0, 64'd0, 3'd0, 64'h1, 2'd0, 1'b1, 2'd3, 64'h8}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; base_i = v.base; idx_en_i = v.en; idx_i = v.idx;
    idx_scale_i = v.sc; disp_i = v.disp; disp_cls_i = v.cls;
    disp_bytes_i = v.byt; elem_sz_i = v.esz;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; base_i = '0; idx_en_i = 1'b0; idx_i = '0;
    idx_scale_i = '0; disp_i = '0; disp_cls_i = '0; disp_bytes_i = 1'b0; elem_sz_i = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 valid in reset", {63'd0, out_valid_o}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 valid after reset", {63'd0, out_valid_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vector %0d addr", VECS[i].req, i), addr_o, VECS[i].exp);
      check($sformatf("R1 vector %0d valid", i), {63'd0, out_valid_o}, 64'd1);
    end

    // R2 hold: change inputs with in_valid low
    apply('{8'd1, 64'h4000, 1'b0, 64'd0, 3'd0, 64'h0, 2'd2, 1'b0, 2'd0, 64'h4000});
    check("R1 directed addr", addr_o, 64'h4000);
    @(negedge clk);
    base_i = 64'h1234; disp_i = 64'h55; disp_cls_i = 2'd2;
    @(posedge clk); #1;
    check("R1 valid drops", {63'd0, out_valid_o}, 64'd0);
    check("R2 addr hold 1", addr_o, 64'h4000);
    @(negedge clk); idx_en_i = 1'b1; idx_i = 64'hFF;
    @(posedge clk); #1;
    check("R2 addr hold 2", addr_o, 64'h4000);

    // R8: enable low hides a large index with every scale code
    for (int s = 0; s < 8; s++) begin
      apply('{8'd8, 64'h20, 1'b0, 64'hDEAD_BEEF, s[2:0], 64'h0, 2'd2, 1'b0, 2'd0, 64'h20});
      check($sformatf("R8 scale code %0d", s), addr_o, 64'h20);
    end

    // R9 wrap through negative index times 10
    apply('{8'd9, 64'h64, 1'b1, 64'hFFFF_FFFF_FFFF_FFF6, 3'd5, 64'h0, 2'd0, 1'b0, 2'd0, 64'h0});
    check("R9 negative index wrap", addr_o, 64'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule